// File: doc/BRIEF.md
# Float to Integer Truncating Converter

This block takes a floating-point operand that is already unpacked into a class code, a sign, an unbiased exponent and a normalised mantissa. It produces a signed two's-complement integer of width `W`, which is 32 or 64. The conversion always truncates toward zero. It has no rounding-mode input, so any mode configured elsewhere has no effect on it.

Values outside the integer range saturate. The saturation bound depends on the sign, so the most negative integer can still be produced exactly. Infinities and NaNs are rejected as invalid. Two flags come with the result. One reports that nonzero fraction bits were discarded. The other reports an invalid conversion.

A pulse on `in_valid` captures one operand. Result and flags appear on the registered outputs one cycle later, together with `out_valid`. They stay there until the next operand is captured.

A two-state machine drives `out_valid`:

- `ST_IDLE` moves to `ST_PRESENT` when `in_valid` is high. Otherwise it stays in `ST_IDLE`.
- `ST_PRESENT` stays in `ST_PRESENT` when `in_valid` is high, which covers back-to-back operands.
- `ST_PRESENT` returns to `ST_IDLE` when `in_valid` is low.

Top module: `ftoi_trunc`

## Requirements
- R1: The class code is 0 for zero, 1 for a finite number, 2 for infinity and 3 for NaN. A zero-class operand gives result 0 with both flags clear, whatever its sign, exponent and mantissa.
- R2: A numeric operand has value `mant * 2^(exp-(MW-1))`, so mantissa bit MW-1 carries weight 2^exp. For 0 <= exp < W, the result magnitude is that value truncated toward zero.
- R3: A numeric operand with a negative exponent gives result 0. Its lost-bits flag is set exactly when the mantissa is nonzero.
- R4: For a numeric operand that is in range, the lost-bits flag is set exactly when a nonzero bit lies below the integer part.
- R5: A numeric operand is invalid when exp >= W, or when its truncated magnitude is at least 2^(W-1) plus the sign bit. In that case the result saturates to 2^(W-1)-1 for a positive operand and to -2^(W-1) for a negative one. The invalid flag is set and the lost-bits flag is clear.
- R6: A negative operand of magnitude exactly 2^(W-1) gives -2^(W-1) with no invalid flag.
- R7: Infinity and NaN operands set the invalid flag and saturate by sign, as in R5, with the lost-bits flag clear.
- R8: A negative in-range operand gives the two's-complement negation of its truncated magnitude.
- R9: `out_valid` is high in the cycle after each cycle in which `in_valid` was high, and low otherwise. Result and flags change only in the cycle after `in_valid` and hold otherwise.
- R10: After reset, `out_valid`, the result and both flags are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Capture strobe for the operand |
| in_class | input | 2 | Operand class code (R1) |
| in_sign | input | 1 | Operand sign, 1 = negative |
| in_exp | input | EW | Unbiased exponent, signed |
| in_mant | input | MW | Normalised mantissa, top bit has weight 2^exp |
| out_valid | output | 1 | Result present this cycle |
| result | output | W | Signed integer result |
| lost_bits | output | 1 | Nonzero fraction bits were discarded |
| invalid | output | 1 | Invalid conversion, result saturated |

## Verification
The bench targets the edges of the range, where a slip is easiest to miss:

- **Positive 2^31 and negative 2^31.** The positive case must be refused. The negative case is the one extra value allowed. A bound that ignores the sign would either saturate -2^31 or let +2^31 wrap to a negative number.
- **Exponent equal to W, and very large or very negative exponents.** A shifter that wraps its shift count would return garbage here instead of saturating or returning 0.
- **Fractions and sub-one values.** These test the lost-bits flag, which a shifter that examines only the guard bit would miss.
- **Zero-class operands carrying nonzero fields.** These expose a design that decodes the mantissa regardless of class.
- **Idle cycles after a result.** These catch a design whose outputs fail to hold.

// File: rtl/ftoi_pkg.sv
package ftoi_pkg;

    typedef enum logic [1:0] {
        FC_ZERO = 2'd0,
        FC_NUM  = 2'd1,
        FC_INF  = 2'd2,
        FC_NAN  = 2'd3
    } fclass_e;

    typedef enum logic {
        ST_IDLE    = 1'b0,
        ST_PRESENT = 1'b1
    } pstate_e;

endpackage

// File: rtl/ftoi_align.sv
// Aligns the mantissa so that its integer part sits in the low W bits,
// and gathers every discarded bit into a single lost-bits indication.
module ftoi_align #(
    parameter int W  = 32,
    parameter int MW = 40,
    parameter int EW = 10
) (
    input  logic [MW-1:0]        mant,
    input  logic signed [EW-1:0] exp_i,
    output logic [W-1:0]         mag,
    output logic                 lost,
    output logic                 too_big
);
    localparam int SW = EW + $clog2(MW) + 2;

    logic signed [SW-1:0] exp_x;
    logic signed [SW-1:0] sh;
    logic [SW-1:0]        sh_u;

    always_comb begin
        exp_x   = {{(SW-EW){exp_i[EW-1]}}, exp_i};
        sh      = SW'(MW - 1) - exp_x;
        sh_u    = unsigned'(sh);
        too_big = (exp_x >= SW'(W));

        if (sh >= SW'(MW)) begin
            // negative exponent: nothing reaches the integer part
            mag  = '0;
            lost = |mant;
        end else if (too_big) begin
            mag  = '0;
            lost = 1'b0;
        end else begin
            mag  = W'(mant >> sh_u);
            lost = |(mant & ~({MW{1'b1}} << sh_u));
        end
    end

endmodule

// File: rtl/ftoi_range.sv
// Range check, sign application and saturation.
module ftoi_range
    import ftoi_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [1:0]   cls,
    input  logic         sign,
    input  logic [W-1:0] mag,
    input  logic         lost_in,
    input  logic         too_big,
    output logic [W-1:0] value,
    output logic         lost,
    output logic         invalid
);
    logic [W:0]   limit;
    logic [W-1:0] sat;
    logic         ovf;

    always_comb begin
        limit = ((W+1)'(1) << (W-1)) + {{W{1'b0}}, sign};
        sat   = {1'b0, {(W-1){1'b1}}} + {{(W-1){1'b0}}, sign};
        ovf   = too_big | ({1'b0, mag} >= limit);

        value   = '0;
        lost    = 1'b0;
        invalid = 1'b0;

        unique case (fclass_e'(cls))
            FC_ZERO: begin
                value = '0;
            end
            FC_NUM: begin
                if (ovf) begin
                    value   = sat;
                    invalid = 1'b1;
                end else begin
                    value = sign ? (~mag + W'(1)) : mag;
                    lost  = lost_in;
                end
            end
            default: begin
                value   = sat;
                invalid = 1'b1;
            end
        endcase
    end

endmodule

// File: rtl/ftoi_trunc.sv
module ftoi_trunc
    import ftoi_pkg::*;
#(
    parameter int W  = 32,
    parameter int MW = 40,
    parameter int EW = 10
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 in_valid,
    input  logic [1:0]           in_class,
    input  logic                 in_sign,
    input  logic signed [EW-1:0] in_exp,
    input  logic [MW-1:0]        in_mant,
    output logic                 out_valid,
    output logic [W-1:0]         result,
    output logic                 lost_bits,
    output logic                 invalid
);
    pstate_e      state_q, state_d;
    logic [W-1:0] mag;
    logic         lost_a, too_big;
    logic [W-1:0] value_c;
    logic         lost_c, inv_c;
    logic [W-1:0] result_q;
    logic         lost_q, inv_q;

    initial begin
        if (MW < W) $error("mantissa narrower than integer width");
    end

    ftoi_align #(.W(W), .MW(MW), .EW(EW)) u_align (
        .mant    (in_mant),
        .exp_i   (in_exp),
        .mag     (mag),
        .lost    (lost_a),
        .too_big (too_big)
    );

    ftoi_range #(.W(W)) u_range (
        .cls     (in_class),
        .sign    (in_sign),
        .mag     (mag),
        .lost_in (lost_a),
        .too_big (too_big),
        .value   (value_c),
        .lost    (lost_c),
        .invalid (inv_c)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:    if (in_valid)  state_d = ST_PRESENT;
            ST_PRESENT: if (!in_valid) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            result_q <= '0;
            lost_q   <= 1'b0;
            inv_q    <= 1'b0;
        end else if (in_valid) begin
            result_q <= value_c;
            lost_q   <= lost_c;
            inv_q    <= inv_c;
        end
    end

    assign out_valid = (state_q == ST_PRESENT);
    assign result    = result_q;
    assign lost_bits = lost_q;
    assign invalid   = inv_q;

    // R9: a captured operand is presented on the next cycle
    a_r9_latency: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);

    // R9: outputs hold while nothing is captured
    a_r9_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(result) && $stable(invalid) && $stable(lost_bits));

    // R1: zero class is clean
    a_r1_zero_clean: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == 2'd0 |=> result == '0 && !lost_bits && !invalid);

    // R3: negative exponent yields zero
    a_r3_neg_exp_zero: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class == 2'd1 && in_exp < 0 |=> result == '0 && !invalid);

    // R7: infinities and NaNs are invalid
    a_r7_special_invalid: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_class[1] |=> invalid && !lost_bits);

    // R5: an invalid result is always one of the two saturation values
    a_r5_saturated: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && invalid |->
            (result == {1'b0, {(W-1){1'b1}}} || result == {1'b1, {(W-1){1'b0}}}));

endmodule

// File: tb/tb_ftoi_trunc.sv
module tb_ftoi_trunc;
    localparam int W  = 32;
    localparam int MW = 40;
    localparam int EW = 10;

    typedef struct packed {
        logic [1:0]    cls;
        logic          sign;
        logic [EW-1:0] exp;
        logic [MW-1:0] mant;
        logic [W-1:0]  res;
        logic          lost;
        logic          inv;
    } vec_t;

    localparam int NV = 19;
    localparam vec_t VECS [NV] = '{
        '{2'd0, 1'b0, 10'h000, 40'h0,          32'h00000000, 1'b0, 1'b0}, // R1 zero
        '{2'd0, 1'b1, 10'h01F, 40'hFF00000001, 32'h00000000, 1'b0, 1'b0}, // R1 zero, fields ignored
        '{2'd1, 1'b0, 10'h000, 40'h8000000000, 32'h00000001, 1'b0, 1'b0}, // R2 1.0
        '{2'd1, 1'b0, 10'h000, 40'hC000000000, 32'h00000001, 1'b1, 1'b0}, // R4 1.5
        '{2'd1, 1'b1, 10'h000, 40'hC000000000, 32'hFFFFFFFF, 1'b1, 1'b0}, // R8 -1.5
        '{2'd1, 1'b0, 10'h3FF, 40'h8000000000, 32'h00000000, 1'b1, 1'b0}, // R3 0.5
        '{2'd1, 1'b0, 10'h20C, 40'h8000000000, 32'h00000000, 1'b1, 1'b0}, // R3 exp -500
        '{2'd1, 1'b1, 10'h3FD, 40'h0,          32'h00000000, 1'b0, 1'b0}, // R3 zero mantissa
        '{2'd1, 1'b0, 10'h01F, 40'h8000000000, 32'h7FFFFFFF, 1'b0, 1'b1}, // R5 +2^31
        '{2'd1, 1'b1, 10'h01F, 40'h8000000000, 32'h80000000, 1'b0, 1'b0}, // R6 -2^31
        '{2'd1, 1'b1, 10'h01F, 40'h8000000100, 32'h80000000, 1'b0, 1'b1}, // R5 -(2^31+1)
        '{2'd1, 1'b0, 10'h01E, 40'hFFFFFFFE00, 32'h7FFFFFFF, 1'b0, 1'b0}, // R2 2^31-1
        '{2'd1, 1'b0, 10'h020, 40'h8000000000, 32'h7FFFFFFF, 1'b0, 1'b1}, // R5 exp = W
        '{2'd1, 1'b1, 10'h1FF, 40'hC000000000, 32'h80000000, 1'b0, 1'b1}, // R5 exp 511
        '{2'd2, 1'b1, 10'h000, 40'h0,          32'h80000000, 1'b0, 1'b1}, // R7 -inf
        '{2'd3, 1'b0, 10'h000, 40'hC000000000, 32'h7FFFFFFF, 1'b0, 1'b1}, // R7 NaN
        '{2'd3, 1'b1, 10'h005, 40'h4000000000, 32'h80000000, 1'b0, 1'b1}, // R7 -NaN
        '{2'd1, 1'b1, 10'h005, 40'hA500000000, 32'hFFFFFFD7, 1'b1, 1'b0}, // R8 -41.25
        '{2'd1, 1'b0, 10'h003, 40'h9000000000, 32'h00000009, 1'b0, 1'b0}  // R2 9 exact
    };

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 in_valid = 1'b0;
    logic [1:0]           in_class = 2'd0;
    logic                 in_sign = 1'b0;
    logic signed [EW-1:0] in_exp = '0;
    logic [MW-1:0]        in_mant = '0;
    logic                 out_valid;
    logic [W-1:0]         result;
    logic                 lost_bits;
    logic                 invalid;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    ftoi_trunc #(.W(W), .MW(MW), .EW(EW)) dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_class  (in_class),
        .in_sign   (in_sign),
        .in_exp    (in_exp),
        .in_mant   (in_mant),
        .out_valid (out_valid),
        .result    (result),
        .lost_bits (lost_bits),
        .invalid   (invalid)
    );

    task automatic check(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, got, exp);
        end
    endtask

    task automatic apply(input vec_t v);
        @(negedge clk);
        in_valid = 1'b1;
        in_class = v.cls;
        in_sign  = v.sign;
        in_exp   = v.exp;
        in_mant  = v.mant;
        @(negedge clk);
        in_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10 reset state
        check("R10 out_valid", 64'(out_valid), 64'd0);
        check("R10 result",    64'(result),    64'd0);
        check("R10 flags",     64'({lost_bits, invalid}), 64'd0);
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i]);
            check($sformatf("R9 out_valid vec %0d", i), 64'(out_valid), 64'd1);
            check($sformatf("R2/R5/R8 result vec %0d", i), 64'(result), 64'(VECS[i].res));
            check($sformatf("R4 lost vec %0d", i), 64'(lost_bits), 64'(VECS[i].lost));
            check($sformatf("R7 invalid vec %0d", i), 64'(invalid), 64'(VECS[i].inv));
        end

        // R9: outputs hold while idle, with input fields changing
        @(negedge clk);
        in_class = 2'd3;
        in_sign  = 1'b0;
        in_mant  = 40'h1234567890;
        @(negedge clk);
        check("R9 idle out_valid", 64'(out_valid), 64'd0);
        check("R9 idle hold result", 64'(result), 64'h00000009);
        check("R9 idle hold invalid", 64'(invalid), 64'd0);

        // R9: back-to-back operands
        @(negedge clk);
        in_valid = 1'b1;
        in_class = 2'd1; in_sign = 1'b0; in_exp = 10'sd1; in_mant = 40'hC000000000;
        @(negedge clk);
        check("R9 b2b first", 64'(result), 64'd3);
        in_class = 2'd1; in_sign = 1'b1; in_exp = 10'sd2; in_mant = 40'hE000000000;
        @(negedge clk);
        in_valid = 1'b0;
        check("R9 b2b second", 64'(result), 64'hFFFFFFF9);
        check("R9 b2b valid", 64'(out_valid), 64'd1);

        // R10: reset mid-run clears outputs
        rst_n = 1'b0;
        @(negedge clk);
        check("R10 reset result", 64'(result), 64'd0);
        check("R10 reset valid", 64'(out_valid), 64'd0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (5000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog actual timeout expected completion");
            end
        join_any
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule